// File: doc/BRIEF.md
# Bus Master Retry and Response Timeout Monitor

This block sits beside the master side of a parallel, PCI-style bus and decides when the master should stop waiting on a target. It applies two separate policies. The first counts retry responses to the current transaction and asks for termination once the count goes past a programmed limit. The second counts bus clocks in which a target has claimed a data phase but has signalled neither ready nor stop, and asks for a master abort once that count reaches its limit. Either policy is switched off by programming its limit to zero.

Both limits share one 32-bit limit word that software can read and write with per-byte enables, so each field can be changed on its own. A second word holds two sticky flags that record each expiry and are cleared by writing one. The bus protocol engine, address decoding and data movement are outside this block. The engine gives it the target strobes as active-high levels, a tenure flag, and pulses that mark a new transaction and a normal completion.

Each policy is a small state machine. The retry machine has the states RT_IDLE (no retries counted), RT_COUNT (one or more retries counted) and RT_EXPIRE (termination pulse). Its transitions are: RT_IDLE to RT_COUNT on the first counted retry; RT_COUNT to RT_EXPIRE on the retry that exceeds the limit; RT_COUNT to RT_IDLE on a clear or a zero limit; RT_EXPIRE to RT_COUNT on a retry, otherwise to RT_IDLE. The wait machine has the states WT_IDLE, WT_STALL (stall clocks being counted) and WT_ABORT (abort pulse). Its transitions are: WT_IDLE to WT_STALL on a stall clock; WT_STALL to WT_ABORT when the count reaches the limit; WT_STALL to WT_IDLE on any clock without a stall; WT_ABORT to WT_STALL or WT_ABORT on a further stall, otherwise to WT_IDLE.

Top module: `bus_wait_monitor`

## Requirements
- R1: After reset, the limit word (cfg_addr 0) reads 0x00008080, with the wait limit in bits 7:0 and the retry limit in bits 15:8. The status word (cfg_addr 1) reads 0, and neither retry_term nor wait_abort is high.
- R2: A write to cfg_addr 0 changes bits 7:0 only when cfg_be[0] is set and bits 15:8 only when cfg_be[1] is set. Bits 31:16 always read 0, and writes to them have no effect.
- R3: A retry event is a clock where txn_active, tgt_claim and tgt_stop are high and tgt_ready is low. With a retry limit L above 0, the (L+1)th counted retry makes retry_term high for exactly the next cycle, and counting then starts again from zero.
- R4: With a retry limit of 0, retry_term never rises, whatever the number of retries.
- R5: A clock with txn_start or txn_done high clears the retry count, and a retry event in that same clock is not counted. Dropping txn_active between a retry and the reissue does not clear the count.
- R6: A stall clock is one where txn_active and tgt_claim are high while tgt_ready and tgt_stop are low. With a wait limit W above 0, wait_abort is high for exactly the cycle after the Wth consecutive stall clock. A stall that continues afterwards is counted again from zero.
- R7: Any clock that is not a stall clock clears the stall count: ready seen, stop seen, claim low, or txn_active low.
- R8: With a wait limit of 0, wait_abort never rises, however long the stall lasts.
- R9: The status word bit 0 is set in the cycle after a retry_term pulse and bit 1 in the cycle after a wait_abort pulse. A write to cfg_addr 1 with cfg_be[0] set clears each bit that is written as 1. A set in the same clock as a clear wins.
- R10: Counting always compares against the current limit. If a limit is lowered to or below the count already reached, the next counted event expires that policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Word select: 0 limit word, 1 status word |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected word (combinational) |
| txn_active | input | 1 | Master holds a bus tenure |
| txn_start | input | 1 | Pulse: a new transaction begins (not a reissue) |
| txn_done | input | 1 | Pulse: the transaction completed normally |
| tgt_claim | input | 1 | Target has claimed the access (device select) |
| tgt_ready | input | 1 | Target ready for the data phase |
| tgt_stop | input | 1 | Target requests stop |
| retry_term | output | 1 | One-cycle request to terminate after too many retries |
| wait_abort | output | 1 | One-cycle request for a master abort after a stall |

## Verification
The hardest cases to reach are those where the limit changes under a count already in progress, and where an expiry pulse lands in the same clock as a software clear of its sticky flag. From the ports, both depend on getting the write into one exact clock relative to the bus activity. The stimulus builds up a partial count with separated retry events, or with a held stall, and then writes the new limit or the clearing value in a chosen clock. A behavioural model that tracks counts as plain integers predicts every output and read-back value on every clock. Long runs of stalls and retries with a zero limit, and stalls broken by each of the four possible causes, fill out the remaining corners.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    // Word select on the configuration port
    localparam logic ADDR_LIMITS = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    // Status word bit positions
    localparam int STAT_RETRY_BIT = 0;
    localparam int STAT_WAIT_BIT  = 1;

    typedef enum logic [1:0] {
        RT_IDLE   = 2'd0,
        RT_COUNT  = 2'd1,
        RT_EXPIRE = 2'd2
    } retry_state_t;

    typedef enum logic [1:0] {
        WT_IDLE  = 2'd0,
        WT_STALL = 2'd1,
        WT_ABORT = 2'd2
    } wait_state_t;

endpackage

// File: rtl/bwm_cfg_regs.sv
module bwm_cfg_regs
    import bwm_pkg::*;
#(
    parameter int          LIM_W     = 8,
    parameter int          DATA_W    = 32,
    parameter int unsigned RETRY_RST = 128,
    parameter int unsigned WAIT_RST  = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  addr,
    input  logic [DATA_W/8-1:0]   be,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  retry_hit,
    input  logic                  wait_hit,
    output logic [DATA_W-1:0]     rdata,
    output logic [LIM_W-1:0]      retry_lim,
    output logic [LIM_W-1:0]      wait_lim,
    output logic                  retry_flag,
    output logic                  wait_flag
);

    localparam int BE_W     = DATA_W / 8;
    localparam int WAIT_LO  = 0;
    localparam int RETRY_LO = LIM_W;

    logic [LIM_W-1:0] wait_mask;
    logic [LIM_W-1:0] retry_mask;
    logic             lim_wr;
    logic             stat_wr;
    logic             clr_retry;
    logic             clr_wait;

    // Per-bit write mask taken from the byte lane that holds the bit
    genvar g;
    generate
        for (g = 0; g < LIM_W; g++) begin : g_lane
            assign wait_mask[g]  = be[(WAIT_LO + g) / 8];
            assign retry_mask[g] = be[(RETRY_LO + g) / 8];
        end
    endgenerate

    assign lim_wr    = wr && (addr == ADDR_LIMITS);
    assign stat_wr   = wr && (addr == ADDR_STATUS) && be[0];
    assign clr_retry = stat_wr && wdata[STAT_RETRY_BIT];
    assign clr_wait  = stat_wr && wdata[STAT_WAIT_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            retry_lim <= LIM_W'(RETRY_RST);
            wait_lim  <= LIM_W'(WAIT_RST);
        end else if (lim_wr) begin
            wait_lim  <= (wait_lim & ~wait_mask)
                       | (wdata[WAIT_LO +: LIM_W] & wait_mask);
            retry_lim <= (retry_lim & ~retry_mask)
                       | (wdata[RETRY_LO +: LIM_W] & retry_mask);
        end
    end

    // Sticky flags: a new expiry wins over a clear in the same clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            retry_flag <= 1'b0;
            wait_flag  <= 1'b0;
        end else begin
            retry_flag <= retry_hit | (retry_flag & ~clr_retry);
            wait_flag  <= wait_hit  | (wait_flag  & ~clr_wait);
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_LIMITS: begin
                rdata[WAIT_LO +: LIM_W]  = wait_lim;
                rdata[RETRY_LO +: LIM_W] = retry_lim;
            end
            ADDR_STATUS: begin
                rdata[STAT_RETRY_BIT] = retry_flag;
                rdata[STAT_WAIT_BIT]  = wait_flag;
            end
            default: rdata = '0;
        endcase
    end

    logic unused_be;
    assign unused_be = ^be[BE_W-1:0];

endmodule

// File: rtl/bwm_retry_fsm.sv
module bwm_retry_fsm
    import bwm_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LIM_W-1:0] limit,
    input  logic             retry_ev,
    input  logic             clear,
    output logic             term
);

    localparam int CNT_W = LIM_W + 1;

    retry_state_t     state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] lim_ext;
    logic             enabled;

    assign enabled = (limit != '0);
    assign lim_ext = {1'b0, limit};
    assign cnt_inc = cnt + CNT_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RT_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            RT_IDLE, RT_EXPIRE: begin
                state_n = RT_IDLE;
                cnt_n   = '0;
                if (!clear && enabled && retry_ev) begin
                    state_n = RT_COUNT;
                    cnt_n   = CNT_W'(1);
                end
            end
            RT_COUNT: begin
                if (clear || !enabled) begin
                    state_n = RT_IDLE;
                    cnt_n   = '0;
                end else if (retry_ev) begin
                    if (cnt_inc > lim_ext) begin
                        state_n = RT_EXPIRE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
            end
            default: begin
                state_n = RT_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        term = (state == RT_EXPIRE);
    end

endmodule

// File: rtl/bwm_wait_fsm.sv
module bwm_wait_fsm
    import bwm_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LIM_W-1:0] limit,
    input  logic             stall,
    output logic             abort
);

    localparam int CNT_W = LIM_W + 1;

    wait_state_t      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] lim_ext;
    logic             enabled;

    assign enabled = (limit != '0);
    assign lim_ext = {1'b0, limit};
    assign cnt_inc = cnt + CNT_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WT_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            WT_IDLE, WT_ABORT: begin
                state_n = WT_IDLE;
                cnt_n   = '0;
                if (stall && enabled) begin
                    if (lim_ext == CNT_W'(1)) begin
                        state_n = WT_ABORT;
                    end else begin
                        state_n = WT_STALL;
                        cnt_n   = CNT_W'(1);
                    end
                end
            end
            WT_STALL: begin
                if (!stall || !enabled) begin
                    state_n = WT_IDLE;
                    cnt_n   = '0;
                end else if (cnt_inc >= lim_ext) begin
                    state_n = WT_ABORT;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_inc;
                end
            end
            default: begin
                state_n = WT_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        abort = (state == WT_ABORT);
    end

endmodule

// File: rtl/bus_wait_monitor.sv
module bus_wait_monitor
    import bwm_pkg::*;
#(
    parameter int          LIM_W     = 8,
    parameter int          DATA_W    = 32,
    parameter int unsigned RETRY_RST = 128,
    parameter int unsigned WAIT_RST  = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_addr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic                txn_active,
    input  logic                txn_start,
    input  logic                txn_done,
    input  logic                tgt_claim,
    input  logic                tgt_ready,
    input  logic                tgt_stop,
    output logic                retry_term,
    output logic                wait_abort
);

    logic [LIM_W-1:0] retry_lim;
    logic [LIM_W-1:0] wait_lim;
    logic             retry_flag;
    logic             wait_flag;
    logic             retry_ev;
    logic             stall;
    logic             txn_clear;

    // A retry: claimed, stop without ready. A stall: claimed, neither strobe.
    assign retry_ev  = txn_active && tgt_claim && tgt_stop && !tgt_ready;
    assign stall     = txn_active && tgt_claim && !tgt_stop && !tgt_ready;
    assign txn_clear = txn_start || txn_done;

    bwm_cfg_regs #(
        .LIM_W     (LIM_W),
        .DATA_W    (DATA_W),
        .RETRY_RST (RETRY_RST),
        .WAIT_RST  (WAIT_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .addr       (cfg_addr),
        .be         (cfg_be),
        .wdata      (cfg_wdata),
        .retry_hit  (retry_term),
        .wait_hit   (wait_abort),
        .rdata      (cfg_rdata),
        .retry_lim  (retry_lim),
        .wait_lim   (wait_lim),
        .retry_flag (retry_flag),
        .wait_flag  (wait_flag)
    );

    bwm_retry_fsm #(
        .LIM_W (LIM_W)
    ) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .limit    (retry_lim),
        .retry_ev (retry_ev),
        .clear    (txn_clear),
        .term     (retry_term)
    );

    bwm_wait_fsm #(
        .LIM_W (LIM_W)
    ) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .limit (wait_lim),
        .stall (stall),
        .abort (wait_abort)
    );

endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
    parameter int LIM_W  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_active,
    input logic              tgt_claim,
    input logic              tgt_ready,
    input logic              tgt_stop,
    input logic              retry_term,
    input logic              wait_abort,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic [LIM_W-1:0]  retry_lim,
    input logic [LIM_W-1:0]  wait_lim,
    input logic              retry_flag,
    input logic              wait_flag
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1:2*LIM_W] == '0);

    a_r3_term_after_retry: assert property (@(posedge clk) disable iff (!rst_n)
        retry_term |-> $past(txn_active && tgt_claim && tgt_stop && !tgt_ready));

    a_r3_term_single: assert property (@(posedge clk) disable iff (!rst_n)
        retry_term |=> !retry_term);

    a_r4_term_needs_limit: assert property (@(posedge clk) disable iff (!rst_n)
        retry_term |-> $past(retry_lim) != '0);

    a_r6_abort_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        wait_abort |-> $past(txn_active && tgt_claim && !tgt_stop && !tgt_ready));

    a_r6_abort_single_when_limit_gt1: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_abort && wait_lim > 1) |=> !wait_abort);

    a_r8_abort_needs_limit: assert property (@(posedge clk) disable iff (!rst_n)
        wait_abort |-> $past(wait_lim) != '0);

    a_r9_retry_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        retry_term |=> retry_flag);

    a_r9_wait_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wait_abort |=> wait_flag);

endmodule

bind bus_wait_monitor bwm_checker #(
    .LIM_W  (LIM_W),
    .DATA_W (DATA_W)
) i_bwm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_active (txn_active),
    .tgt_claim  (tgt_claim),
    .tgt_ready  (tgt_ready),
    .tgt_stop   (tgt_stop),
    .retry_term (retry_term),
    .wait_abort (wait_abort),
    .cfg_rdata  (cfg_rdata),
    .retry_lim  (retry_lim),
    .wait_lim   (wait_lim),
    .retry_flag (retry_flag),
    .wait_flag  (wait_flag)
);

// File: tb/test_bus_wait_monitor.sv
`timescale 1ns/1ps
module test_bus_wait_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        txn_active = 1'b0;
    logic        txn_start = 1'b0;
    logic        txn_done = 1'b0;
    logic        tgt_claim = 1'b0;
    logic        tgt_ready = 1'b0;
    logic        tgt_stop = 1'b0;
    logic        retry_term;
    logic        wait_abort;

    always #2 clk = ~clk;   // 250 MHz

    bus_wait_monitor i_bus_wait_monitor (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .txn_active(txn_active), .txn_start(txn_start), .txn_done(txn_done),
        .tgt_claim(tgt_claim), .tgt_ready(tgt_ready), .tgt_stop(tgt_stop),
        .retry_term(retry_term), .wait_abort(wait_abort)
    );

    int    n_tests = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // Behavioural reference model
    int rl, wl, rc, wc, nt, na;
    bit et, ea, rf, wf, ev, stl, clr_r, clr_w;

    always @(posedge clk) begin
        if (!rst_n) begin
            rl = 128; wl = 128; rc = 0; wc = 0;
            et = 0; ea = 0; rf = 0; wf = 0;
        end else begin
            ev  = txn_active && tgt_claim && tgt_stop && !tgt_ready;
            stl = txn_active && tgt_claim && !tgt_stop && !tgt_ready;
            nt = 0;
            if (rl == 0 || txn_start || txn_done) rc = 0;
            else if (ev) begin
                if (rc + 1 > rl) begin nt = 1; rc = 0; end
                else rc = rc + 1;
            end
            na = 0;
            if (stl && wl != 0) begin
                if (wc + 1 >= wl) begin na = 1; wc = 0; end
                else wc = wc + 1;
            end else wc = 0;
            clr_r = cfg_wr && cfg_addr && cfg_be[0] && cfg_wdata[0];
            clr_w = cfg_wr && cfg_addr && cfg_be[0] && cfg_wdata[1];
            rf = et || (rf && !clr_r);
            wf = ea || (wf && !clr_w);
            if (cfg_wr && !cfg_addr) begin
                if (cfg_be[0]) wl = cfg_wdata[7:0];
                if (cfg_be[1]) rl = cfg_wdata[15:8];
            end
            et = nt[0];
            ea = na[0];
        end
    end

    function automatic logic [31:0] exp_rdata();
        if (!cfg_addr) return {16'h0, rl[7:0], wl[7:0]};
        return {30'h0, wf, rf};
    endfunction

    // Compare on every clock, half a period after the edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_tests += 3;
            if (retry_term !== et) begin
                n_fail++;
                $display("FAIL %s retry_term actual %0b expected %0b at %0t", cur_req, retry_term, et, $time);
            end
            if (wait_abort !== ea) begin
                n_fail++;
                $display("FAIL %s wait_abort actual %0b expected %0b at %0t", cur_req, wait_abort, ea, $time);
            end
            if (cfg_rdata !== exp_rdata()) begin
                n_fail++;
                $display("FAIL %s cfg_rdata actual %h expected %h at %0t", cur_req, cfg_rdata, exp_rdata(), $time);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic bus(input bit ta, input bit cl, input bit rd, input bit sp);
        txn_active = ta; tgt_claim = cl; tgt_ready = rd; tgt_stop = sp;
        step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(0, 0, 0, 0);
    endtask

    task automatic wr(input bit a, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        step();
        cfg_wr = 0; cfg_be = '0;
    endtask

    // Retry then a reissue gap with the tenure dropped
    task automatic retries(input int n);
        for (int i = 0; i < n; i++) begin
            bus(1, 1, 0, 1);
            bus(0, 0, 0, 0);
        end
    endtask

    task automatic stalls(input int n);
        for (int i = 0; i < n; i++) bus(1, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset values of both words
        cur_req = "R1"; cfg_addr = 0; idle(2); cfg_addr = 1; idle(1); cfg_addr = 0;
        // R2: byte lanes and reserved bits
        cur_req = "R2";
        wr(0, 4'b1111, 32'hFFFF_0305); idle(1);
        wr(0, 4'b0010, 32'h0000_0700); idle(1);
        wr(0, 4'b0001, 32'h0000_0002); idle(1);
        wr(0, 4'b1100, 32'hFFFF_FFFF); idle(1);
        // R3: retry limit 2, termination on the third, then again
        cur_req = "R3";
        wr(0, 4'b0011, 32'h0000_0200); idle(1);
        retries(3); idle(2); retries(3); idle(2);
        // R5: clears on start and done; reissue does not clear
        cur_req = "R5";
        retries(2); txn_start = 1; step(); txn_start = 0; retries(2); idle(1);
        txn_done = 1; step(); txn_done = 0; retries(2); idle(1);
        txn_start = 1; bus(1, 1, 0, 1); txn_start = 0; retries(2); idle(1);
        retries(1); idle(2);
        // R4: retry limit 0
        cur_req = "R4";
        wr(0, 4'b0010, 32'h0); retries(12); idle(2);
        // R6: wait limit 3, single and continuing stalls
        cur_req = "R6";
        wr(0, 4'b0001, 32'h3); idle(1);
        stalls(3); idle(2); stalls(7); idle(2);
        // R7: each way a stall run is broken
        cur_req = "R7";
        stalls(2); bus(1, 1, 1, 0); stalls(2); idle(1);
        stalls(2); bus(1, 1, 0, 1); stalls(2); idle(1);
        stalls(2); bus(1, 0, 0, 0); stalls(2); idle(1);
        stalls(2); bus(0, 1, 0, 0); stalls(2); idle(1);
        // R8: wait limit 0, long stall
        cur_req = "R8";
        wr(0, 4'b0001, 32'h0); stalls(300); idle(2);
        // R10: limits lowered under a count in progress
        cur_req = "R10";
        wr(0, 4'b0011, 32'h0000_030A); idle(1);
        retries(2); wr(0, 4'b0010, 32'h0000_0100); retries(1); idle(2);
        stalls(5);
        cfg_wr = 1; cfg_addr = 0; cfg_be = 4'b0001; cfg_wdata = 32'h3;
        bus(1, 1, 0, 0);
        cfg_wr = 0; cfg_be = '0;
        stalls(2); idle(2);
        // R9: sticky flags and write-one-to-clear
        cur_req = "R9";
        cfg_addr = 1; idle(1);
        wr(1, 4'b0000, 32'h3); idle(1);
        wr(1, 4'b0001, 32'h2); idle(1);
        wr(1, 4'b0001, 32'h1); idle(1);
        cfg_addr = 0; wr(0, 4'b0001, 32'h1); cfg_addr = 1;
        bus(1, 1, 0, 0);
        cfg_wr = 1; cfg_addr = 1; cfg_be = 4'b0001; cfg_wdata = 32'h3;
        bus(0, 0, 0, 0);
        cfg_wr = 0; cfg_be = '0;
        idle(2);
        wr(1, 4'b0001, 32'h3); idle(2);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog (all) actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule